// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 64 level-sensitive interrupt sources and presents them to a CPU as two request lines, one normal and one fast. Software sets it up through a small 32-bit register bus. Each source can be enabled, asserted by software, steered to either request line, and given a 4-bit priority. A handler reads a vector register that names the winning source. It can keep reading that register until the register reports that nothing is left.

Sources 0 to 31 live in the low word of each register pair and sources 32 to 63 in the high word. Single enable bits can be set or cleared by writing a source number, with no read-modify-write. A 5-bit threshold hides normal sources of low priority from both the normal vector and the normal request line. The request lines and both vectors are registered, so they change together one clock after the state that produced them.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, enable, type, force, priority and control are all 0 and the mask at 0x04 reads 0x1F. Both vector registers read 0xFFFF0000 and both request outputs are low.
- R2: Word pairs are split by source number. The low word (enable 0x14, type 0x1C, force 0x54, raw 0x4C, normal pending 0x5C, fast pending 0x64) holds sources 0–31 at bit i. The high word (0x10, 0x18, 0x50, 0x48, 0x58, 0x60) holds source 32+i at bit i.
- R3: A raw source bit reads as the external level ORed with that source's force bit.
- R4: A source is pending when its raw bit and its enable bit are both 1. A type bit of 1 places it in the fast pending set and a type bit of 0 places it in the normal pending set.
- R5: Priority word n sits at byte address 0x20 + 4·(7−n). Its nibble k, at bits 4k+3:4k, is the priority of source 8n+k. The words read back what was written.
- R6: Bits 31:16 of the normal vector at 0x40 give the number of the eligible normal pending source with the largest priority. At equal priority the higher source number wins. Bits 15:0 read 0.
- R7: Bits 31:16 of a vector read 0xFFFF when that vector has no candidate. A request output is high exactly when its vector holds a source number.
- R8: The fast vector at 0x44 applies the R6 rule to the fast pending set. The threshold does not apply to it.
- R9: A mask of 0x1F admits all normal sources. Any other mask admits to the normal vector and the normal request only sources whose priority is strictly greater than the mask.
- R10: Writing a number from 0 to 63 to 0x08 sets that enable bit, and writing it to 0x0C clears it. Values of 64 or more leave all enables unchanged.
- R11: The request outputs and the vector readouts change on the clock edge after the one that changed enables, levels or other state.
- R12: The control word at 0x00 stores and returns a 32-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_lvl | input | 64 | External level of each source |
| irq_norm | output | 1 | Normal request to the CPU |
| irq_fast | output | 1 | Fast request to the CPU |

## Verification
A wrong enable, type or force bit shows up in the pending and raw words as soon as the next read, and in the vectors one clock later. A wrong priority bit or a reversed word address changes which source wins, and this shows only when two sources compete. For that reason the tests set up ties and near-ties, and move the threshold across the exact priority of the winner. A register stage that is too long or too short is caught by sampling the request line both one and two edges after a change.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSRC = 64,
  parameter int PW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [6:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_lvl,
  output logic            irq_norm,
  output logic            irq_fast
);
  localparam int IW   = $clog2(NSRC);
  localparam int HALF = NSRC / 2;
  localparam int PPW  = 32 / PW;
  localparam logic [4:0] MASK_OFF = 5'h1F;

  logic [31:0]            ctrl;
  logic [4:0]             thr;
  logic [NSRC-1:0]        en, typ, frc;
  logic [NSRC-1:0][PW-1:0] prio;
  logic                   nvld_q, fvld_q;
  logic [IW-1:0]          nidx_q, fidx_q;

  logic [4:0]  wsel;
  logic        num_ok;
  logic [IW-1:0] num;
  assign wsel   = bus_addr[6:2];
  assign num    = bus_wdata[IW-1:0];
  assign num_ok = (bus_wdata[31:IW] == '0);

  logic [NSRC-1:0] raw, npend, fpend, pass, nelig;
  assign raw   = src_lvl | frc;
  assign npend = raw & en & ~typ;
  assign fpend = raw & en & typ;

  for (genvar g = 0; g < NSRC; g++) begin : g_pass
    assign pass[g] = (thr == MASK_OFF) || ({1'b0, prio[g]} > thr);
  end
  assign nelig = npend & pass;

  logic          n_hit, f_hit;
  logic [IW-1:0] n_idx, f_idx;
  logic [PW-1:0] n_best, f_best;

  always_comb begin
    n_hit = 1'b0; n_idx = '0; n_best = '0;
    f_hit = 1'b0; f_idx = '0; f_best = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (nelig[i] && (!n_hit || prio[i] >= n_best)) begin
        n_hit = 1'b1; n_idx = IW'(i); n_best = prio[i];
      end
      if (fpend[i] && (!f_hit || prio[i] >= f_best)) begin
        f_hit = 1'b1; f_idx = IW'(i); f_best = prio[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      thr  <= MASK_OFF;
      en   <= '0;
      typ  <= '0;
      frc  <= '0;
      prio <= '0;
    end else if (bus_wr) begin
      case (wsel)
        5'h00: ctrl <= bus_wdata;
        5'h01: thr  <= bus_wdata[4:0];
        5'h02: if (num_ok) en[num] <= 1'b1;
        5'h03: if (num_ok) en[num] <= 1'b0;
        5'h04: en[NSRC-1:HALF]  <= bus_wdata[HALF-1:0];
        5'h05: en[HALF-1:0]     <= bus_wdata[HALF-1:0];
        5'h06: typ[NSRC-1:HALF] <= bus_wdata[HALF-1:0];
        5'h07: typ[HALF-1:0]    <= bus_wdata[HALF-1:0];
        5'h14: frc[NSRC-1:HALF] <= bus_wdata[HALF-1:0];
        5'h15: frc[HALF-1:0]    <= bus_wdata[HALF-1:0];
        default: begin
          if (wsel[4:3] == 2'b01) begin
            for (int k = 0; k < PPW; k++)
              prio[(7 - int'(wsel[2:0])) * PPW + k] <= bus_wdata[k*PW +: PW];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nvld_q <= 1'b0; nidx_q <= '0; irq_norm <= 1'b0;
      fvld_q <= 1'b0; fidx_q <= '0; irq_fast <= 1'b0;
    end else begin
      nvld_q <= n_hit; nidx_q <= n_idx; irq_norm <= |nelig;
      fvld_q <= f_hit; fidx_q <= f_idx; irq_fast <= |fpend;
    end
  end

  logic [31:0] pword;
  always_comb begin
    pword = '0;
    for (int k = 0; k < PPW; k++)
      pword[k*PW +: PW] = prio[(7 - int'(wsel[2:0])) * PPW + k];
  end

  always_comb begin
    case (wsel)
      5'h00: bus_rdata = ctrl;
      5'h01: bus_rdata = {27'b0, thr};
      5'h04: bus_rdata = en[NSRC-1:HALF];
      5'h05: bus_rdata = en[HALF-1:0];
      5'h06: bus_rdata = typ[NSRC-1:HALF];
      5'h07: bus_rdata = typ[HALF-1:0];
      5'h10: bus_rdata = {nvld_q ? 16'(nidx_q) : 16'hFFFF, 16'h0};
      5'h11: bus_rdata = {fvld_q ? 16'(fidx_q) : 16'hFFFF, 16'h0};
      5'h12: bus_rdata = raw[NSRC-1:HALF];
      5'h13: bus_rdata = raw[HALF-1:0];
      5'h14: bus_rdata = frc[NSRC-1:HALF];
      5'h15: bus_rdata = frc[HALF-1:0];
      5'h16: bus_rdata = npend[NSRC-1:HALF];
      5'h17: bus_rdata = npend[HALF-1:0];
      5'h18: bus_rdata = fpend[NSRC-1:HALF];
      5'h19: bus_rdata = fpend[HALF-1:0];
      default: bus_rdata = (wsel[4:3] == 2'b01) ? pword : 32'h0;
    endcase
  end

  a_r10_set_by_num: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && wsel == 5'h02 && num_ok) |=> en[$past(num)]);
  a_r10_clr_by_num: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && wsel == 5'h03 && num_ok) |=> !en[$past(num)]);
  a_r10_bad_num: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (wsel == 5'h02 || wsel == 5'h03) && !num_ok) |=> $stable(en));
  a_r6_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    n_hit |-> (en[n_idx] && raw[n_idx] && !typ[n_idx]));
  a_r8_fast_winner: assert property (@(posedge clk) disable iff (!rst_n)
    f_hit |-> (en[f_idx] && raw[f_idx] && typ[f_idx]));
  a_r9_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (n_hit && thr != MASK_OFF) |-> ({1'b0, prio[n_idx]} > thr));
  a_r7_norm_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm == nvld_q);
  a_r7_fast_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast == fvld_q);
endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_lvl = '0;
  logic        irq_norm, irq_fast;

  int n_chk = 0;
  int n_err = 0;
  localparam logic [31:0] NONE = 32'hFFFF0000;

  always #2 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src_lvl),
    .irq_norm(irq_norm), .irq_fast(irq_fast));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [6:0] a, logic [31:0] exp);
    bus_addr = a;
    #0.5;
    check(req, bus_rdata, exp);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  function automatic logic [31:0] vec(int n);
    return {16'(n), 16'h0};
  endfunction

  task automatic t_reset();
    rd_chk("R1", 7'h04, 32'h1F);
    rd_chk("R1", 7'h00, 32'h0);
    rd_chk("R1", 7'h10, 32'h0);
    rd_chk("R1", 7'h14, 32'h0);
    rd_chk("R1", 7'h1C, 32'h0);
    rd_chk("R1", 7'h3C, 32'h0);
    rd_chk("R1", 7'h40, NONE);
    rd_chk("R1", 7'h44, NONE);
    check("R1", {30'b0, irq_norm, irq_fast}, 32'h0);
  endtask

  task automatic t_ctrl();
    wr(7'h00, 32'hA5C3_0F1E);
    rd_chk("R12", 7'h00, 32'hA5C3_0F1E);
    wr(7'h00, 32'h0);
  endtask

  task automatic t_timing();
    src_lvl[3] = 1'b1;
    @(negedge clk);
    bus_addr = 7'h14; bus_wdata = 32'h8; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R11 one edge", {31'b0, irq_norm}, 32'h0);
    rd_chk("R11 one edge", 7'h40, NONE);
    @(negedge clk);
    check("R11 two edges", {31'b0, irq_norm}, 32'h1);
    rd_chk("R11 two edges", 7'h40, vec(3));
  endtask

  task automatic t_split();
    src_lvl[40] = 1'b1;
    wr(7'h10, 32'h100);
    settle();
    rd_chk("R2", 7'h10, 32'h100);
    rd_chk("R2", 7'h14, 32'h8);
    rd_chk("R2 R3", 7'h48, 32'h100);
    rd_chk("R2 R3", 7'h4C, 32'h8);
    rd_chk("R2 R4", 7'h58, 32'h100);
    rd_chk("R2 R4", 7'h5C, 32'h8);
    rd_chk("R6 tie higher wins", 7'h40, vec(40));
  endtask

  task automatic t_force();
    wr(7'h54, 32'h20);
    settle();
    rd_chk("R3", 7'h4C, 32'h28);
    rd_chk("R4 not enabled", 7'h5C, 32'h8);
    wr(7'h08, 32'd5);
    settle();
    rd_chk("R4", 7'h5C, 32'h28);
    rd_chk("R10", 7'h14, 32'h28);
    wr(7'h0C, 32'd5);
    wr(7'h54, 32'h0);
    settle();
    rd_chk("R10 clear", 7'h14, 32'h8);
    rd_chk("R3 force off", 7'h4C, 32'h8);
  endtask

  task automatic t_prio();
    wr(7'h3C, 32'h0000_5000);
    settle();
    rd_chk("R5", 7'h3C, 32'h0000_5000);
    rd_chk("R6 higher prio", 7'h40, vec(3));
    wr(7'h28, 32'h0000_0005);
    settle();
    rd_chk("R5", 7'h28, 32'h5);
    rd_chk("R6 tie", 7'h40, vec(40));
    wr(7'h28, 32'h0000_0004);
    settle();
    rd_chk("R6 lower prio loses", 7'h40, vec(3));
    wr(7'h28, 32'h0000_0005);
  endtask

  task automatic t_mask();
    wr(7'h04, 32'h5);
    settle();
    rd_chk("R9 equal blocked", 7'h40, NONE);
    check("R9 req", {31'b0, irq_norm}, 32'h0);
    rd_chk("R9 pending unmasked", 7'h5C, 32'h8);
    wr(7'h04, 32'h4);
    settle();
    rd_chk("R9 above", 7'h40, vec(40));
    check("R9 req", {31'b0, irq_norm}, 32'h1);
    wr(7'h04, 32'h1F);
    settle();
    rd_chk("R9 off", 7'h40, vec(40));
  endtask

  task automatic t_fast();
    wr(7'h1C, 32'h8);
    settle();
    rd_chk("R8", 7'h44, vec(3));
    check("R8 req", {31'b0, irq_fast}, 32'h1);
    rd_chk("R4 fast set", 7'h64, 32'h8);
    rd_chk("R4 normal set", 7'h5C, 32'h0);
    wr(7'h04, 32'hE);
    settle();
    rd_chk("R8 no mask", 7'h44, vec(3));
    rd_chk("R9 normal gone", 7'h40, NONE);
    check("R7 req low", {31'b0, irq_norm}, 32'h0);
    wr(7'h04, 32'h1F);
  endtask

  task automatic t_numbers();
    wr(7'h0C, 32'd40);
    settle();
    rd_chk("R10 disable", 7'h10, 32'h0);
    rd_chk("R7 empty", 7'h40, NONE);
    wr(7'h08, 32'd104);
    settle();
    rd_chk("R10 ignored", 7'h10, 32'h0);
    rd_chk("R10 ignored", 7'h14, 32'h8);
    wr(7'h08, 32'd40);
    settle();
    rd_chk("R10 enable", 7'h10, 32'h100);
    rd_chk("R10 enable", 7'h40, vec(40));
    wr(7'h0C, 32'd70);
    settle();
    rd_chk("R10 ignored", 7'h10, 32'h100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_timing();
    t_split();
    t_force();
    t_prio();
    t_mask();
    t_fast();
    t_numbers();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule